// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a TFT panel: horizontal sync, vertical sync, data enable, a frame-start marker, an uninverted active-pixel strobe, and the column and row of the pixel being described. It walks a pixel counter across each line and a line counter down each frame. The extents come from three 32-bit timing words that software writes. A separate pixel-clock enable gates the stepping, so the block runs from a faster system clock.

The words are captured into a working copy only when a frame begins. Software can therefore rewrite them at any time, and the panel never sees a torn frame. The global enable starts and stops the raster. Dropping it quiets every output within one clock. Raising it again restarts from the top-left pixel with a fresh copy of the words.

Top module: `lcd_raster_gen`

## Requirements
- R1: Horizontal word: bits 7:2 = active pixels/16 - 1, bits 15:8 = sync width - 1, bits 23:16 = front porch - 1, bits 31:24 = back porch - 1. A line is active, then front porch, then sync, then back porch, and `col` counts 0 to total - 1.
- R2: Vertical word: bits 9:0 = active lines - 1, bits 15:10 = sync lines - 1, bits 23:16 = front porch lines and bits 31:24 = back porch lines, with zero allowed for either porch. The order is the same as for a line, and `row` advances only when a line ends.
- R3: `pix_valid` is high exactly when both `col` and `row` lie inside the active area. `col` and `row` give the position described by the other outputs.
- R4: Polarity word: bit 12 inverts `hsync`, bit 11 inverts `vsync` and bit 14 inverts `de`, each by exclusive-OR on an active-high raw level. Bit 13 is driven out on `pclk_fall`. `pix_valid` is never inverted.
- R5: `frame_start` is high for exactly one pixel step per frame, on the step that describes column 0, row 0.
- R6: The words are sampled only when a frame begins. A write in mid-frame changes nothing until the next frame.
- R7: With `enable` low, every output is 0 after the next clock edge, whatever `pix_ce` does. After `enable` rises, the first `pix_ce` step loads the words and leaves the outputs at 0. The following step describes column 0, row 0.
- R8: While `pix_ce` is low and `enable` is high, no output changes.
- R9: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | One-cycle pixel step enable |
| enable | input | 1 | Raster run enable |
| hword | input | 32 | Horizontal timing word |
| vword | input | 32 | Vertical timing word |
| pword | input | 32 | Polarity word |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_valid | output | 1 | Active pixel strobe, always active high |
| frame_start | output | 1 | First pixel of a frame |
| pclk_fall | output | 1 | Selected pixel clock edge |
| col | output | 11 | Column of the described pixel |
| row | output | 11 | Row of the described pixel |

## Verification
The assertions assume that the timing words, as decoded, yield a line and a frame no longer than the 11-bit position range. They also assume that `pix_ce` is a single-cycle qualifier and is not held high across a reset release. The stimulus keeps every field small enough that a frame takes at most a few hundred steps. It changes words and enables only at falling clock edges, and it runs both with `pix_ce` high on every cycle and with gaps of one and two idle cycles. A behavioural raster model in the bench captures the words at its own frame boundary, so mid-frame writes are checked against an independent timeline.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  localparam int WORD_W = 32;
  localparam int POS_W  = 11;

  // horizontal word fields
  localparam int PPL_LSB = 2;
  localparam int PPL_W   = 6;
  localparam int HSW_LSB = 8;
  localparam int HFP_LSB = 16;
  localparam int HBP_LSB = 24;
  localparam int HFLD_W  = 8;
  localparam int BLK_SH  = 4;

  // vertical word fields
  localparam int LPP_LSB = 0;
  localparam int LPP_W   = 10;
  localparam int VSW_LSB = 10;
  localparam int VSW_W   = 6;
  localparam int VFP_LSB = 16;
  localparam int VBP_LSB = 24;
  localparam int VPOR_W  = 8;

  // polarity word bits
  localparam int INV_VS_BIT  = 11;
  localparam int INV_HS_BIT  = 12;
  localparam int PCLK_EDGE_BIT = 13;
  localparam int INV_DE_BIT  = 14;

  typedef struct packed {
    logic [POS_W-1:0] act_end;
    logic [POS_W-1:0] fp_end;
    logic [POS_W-1:0] sync_end;
    logic [POS_W-1:0] last;
  } axis_bounds_t;

  typedef struct packed {
    axis_bounds_t h;
    axis_bounds_t v;
    logic inv_hs;
    logic inv_vs;
    logic inv_de;
    logic pclk_fall;
  } raster_cfg_t;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic pv;
    logic fs;
    logic pf;
    logic [POS_W-1:0] col;
    logic [POS_W-1:0] row;
  } raster_out_t;

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/lcd_timing_decode.sv
module lcd_timing_decode
  import lcd_timing_pkg::*;
(
  input  logic [WORD_W-1:0] hword,
  input  logic [WORD_W-1:0] vword,
  input  logic [WORD_W-1:0] pword,
  output raster_cfg_t       cfg
);
  logic [POS_W-1:0] h_act, h_fp, h_sw, h_bp;
  logic [POS_W-1:0] v_act, v_fp, v_sw, v_bp;
  logic [POS_W-1:0] h_fp_end, h_sync_end, v_fp_end, v_sync_end;
  logic             unused_bits;

  assign unused_bits = ^{hword[PPL_LSB-1:0], pword[WORD_W-1:INV_DE_BIT+1],
                         pword[INV_VS_BIT-1:0]};

  always_comb begin
    // R1: horizontal fields are all stored minus one, active in blocks of 16
    h_act = POS_W'({hword[PPL_LSB +: PPL_W], {BLK_SH{1'b0}}}) + POS_W'(1 << BLK_SH);
    h_fp  = POS_W'(hword[HFP_LSB +: HFLD_W]) + POS_W'(1);
    h_sw  = POS_W'(hword[HSW_LSB +: HFLD_W]) + POS_W'(1);
    h_bp  = POS_W'(hword[HBP_LSB +: HFLD_W]) + POS_W'(1);
    // R2: vertical porches carry no offset
    v_act = POS_W'(vword[LPP_LSB +: LPP_W]) + POS_W'(1);
    v_sw  = POS_W'(vword[VSW_LSB +: VSW_W]) + POS_W'(1);
    v_fp  = POS_W'(vword[VFP_LSB +: VPOR_W]);
    v_bp  = POS_W'(vword[VBP_LSB +: VPOR_W]);

    h_fp_end   = h_act + h_fp;
    h_sync_end = h_fp_end + h_sw;
    v_fp_end   = v_act + v_fp;
    v_sync_end = v_fp_end + v_sw;

    cfg.h.act_end  = h_act;
    cfg.h.fp_end   = h_fp_end;
    cfg.h.sync_end = h_sync_end;
    cfg.h.last     = h_sync_end + h_bp - POS_W'(1);
    cfg.v.act_end  = v_act;
    cfg.v.fp_end   = v_fp_end;
    cfg.v.sync_end = v_sync_end;
    cfg.v.last     = v_sync_end + v_bp - POS_W'(1);
    cfg.inv_hs     = pword[INV_HS_BIT];
    cfg.inv_vs     = pword[INV_VS_BIT];
    cfg.inv_de     = pword[INV_DE_BIT];
    cfg.pclk_fall  = pword[PCLK_EDGE_BIT];
  end
endmodule

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] pos,
  output logic         wrap
);
  logic [W-1:0] pos_q, pos_d;

  assign wrap = step && (pos_q == last);
  assign pos  = pos_q;

  always_comb begin
    pos_d = pos_q;
    if (clr)       pos_d = '0;
    else if (step) pos_d = wrap ? '0 : pos_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R1 R2
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= last);
endmodule

// File: rtl/lcd_raster_out.sv
module lcd_raster_out
  import lcd_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             run,
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] vpos,
  input  raster_cfg_t      cfg,
  output raster_out_t      out
);
  raster_out_t out_q, out_d;
  logic h_act, v_act, h_sync, v_sync, act;

  always_comb begin
    h_act  = hpos < cfg.h.act_end;
    v_act  = vpos < cfg.v.act_end;
    h_sync = (hpos >= cfg.h.fp_end) && (hpos < cfg.h.sync_end);
    v_sync = (vpos >= cfg.v.fp_end) && (vpos < cfg.v.sync_end);
    act    = h_act && v_act;

    out_d = out_q;
    if (clr) begin
      out_d = '0;
    end else if (upd) begin
      out_d = '0;
      if (run) begin
        // R4: raw levels are active high, polarity applied by XOR
        out_d.hs  = h_sync ^ cfg.inv_hs;
        out_d.vs  = v_sync ^ cfg.inv_vs;
        out_d.de  = act ^ cfg.inv_de;
        out_d.pv  = act;
        out_d.fs  = (hpos == '0) && (vpos == '0);
        out_d.pf  = cfg.pclk_fall;
        out_d.col = hpos;
        out_d.row = vpos;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign out = out_q;

  // R5
  fs_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.fs |-> (out_q.pv && out_q.col == '0 && out_q.row == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(out_q));

  // R3
  pv_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.pv |-> (out_q.col < cfg.h.act_end && out_q.row < cfg.v.act_end));
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              enable,
  input  logic [WORD_W-1:0] hword,
  input  logic [WORD_W-1:0] vword,
  input  logic [WORD_W-1:0] pword,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              pix_valid,
  output logic              frame_start,
  output logic              pclk_fall,
  output logic [POS_W-1:0]  col,
  output logic [POS_W-1:0]  row
);
  logic             rst_s;
  raster_cfg_t      cfg_in, cfg_q, cfg_d;
  raster_out_t      out_w;
  logic             run_q, run_d;
  logic             h_step, h_wrap, v_wrap, load, stop;
  logic [POS_W-1:0] hpos, vpos;

  lcd_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_s));

  lcd_timing_decode u_dec (.hword(hword), .vword(vword), .pword(pword), .cfg(cfg_in));

  assign stop   = !enable;
  assign h_step = enable && run_q && pix_ce;
  // R6: capture only at the start of a run or at the end of a frame
  assign load   = enable && pix_ce && (!run_q || v_wrap);

  always_comb begin
    run_d = run_q;
    if (stop)        run_d = 1'b0;
    else if (pix_ce) run_d = 1'b1;
    cfg_d = load ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      run_q <= run_d;
      cfg_q <= cfg_d;
    end
  end

  lcd_axis_counter #(.W(POS_W)) u_hcnt (
    .clk(clk), .rst_n(rst_s), .clr(stop), .step(h_step),
    .last(cfg_q.h.last), .pos(hpos), .wrap(h_wrap));

  lcd_axis_counter #(.W(POS_W)) u_vcnt (
    .clk(clk), .rst_n(rst_s), .clr(stop), .step(h_wrap),
    .last(cfg_q.v.last), .pos(vpos), .wrap(v_wrap));

  lcd_raster_out u_out (
    .clk(clk), .rst_n(rst_s), .clr(stop), .upd(pix_ce), .run(run_q),
    .hpos(hpos), .vpos(vpos), .cfg(cfg_q), .out(out_w));

  assign hsync       = out_w.hs;
  assign vsync       = out_w.vs;
  assign de          = out_w.de;
  assign pix_valid   = out_w.pv;
  assign frame_start = out_w.fs;
  assign pclk_fall   = out_w.pf;
  assign col         = out_w.col;
  assign row         = out_w.row;

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !enable |=> (!hsync && !vsync && !de && !pix_valid && !frame_start &&
                 !pclk_fall && col == '0 && row == '0));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (run_q && !v_wrap) |=> $stable(cfg_q));

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (enable && !h_wrap) |=> $stable(vpos));
endmodule

// File: tb/tb_lcd_raster_gen.sv
module tb_lcd_raster_gen;
  localparam int NV = 4;
  localparam logic [31:0] VEC_H [NV] = '{32'h0000_0000, 32'h0301_0204, 32'h0002_0400, 32'h0000_0000};
  localparam logic [31:0] VEC_V [NV] = '{32'h0000_0002, 32'h0102_0401, 32'h0201_0000, 32'h0000_0800};
  localparam logic [31:0] VEC_P [NV] = '{32'h0000_0000, 32'h001F_7800, 32'h0000_4000, 32'h0000_1000};
  localparam int          VEC_GAP [NV] = '{0, 0, 2, 1};
  localparam int          VEC_FRAME [NV] = '{76, 287, 125, 76};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b0;
  logic enable = 1'b0;
  logic [31:0] hword = '0, vword = '0, pword = '0;
  logic hsync, vsync, de, pix_valid, frame_start, pclk_fall;
  logic [10:0] col, row;
  logic [27:0] obs;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int bh, bv, step_n, fs_first, fs_second;
  int m_hact, m_hfp, m_hsw, m_hbp, m_vact, m_vfp, m_vsw, m_vbp;
  bit m_ih, m_iv, m_ide, m_pf;

  always #2 clk = ~clk;

  lcd_raster_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .enable(enable),
    .hword(hword), .vword(vword), .pword(pword),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_valid(pix_valid),
    .frame_start(frame_start), .pclk_fall(pclk_fall), .col(col), .row(row));

  assign obs = {hsync, vsync, de, pix_valid, frame_start, pclk_fall, col, row};

  task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_load();
    m_hact = (int'(hword[7:2]) + 1) * 16;
    m_hsw  = int'(hword[15:8]) + 1;
    m_hfp  = int'(hword[23:16]) + 1;
    m_hbp  = int'(hword[31:24]) + 1;
    m_vact = int'(vword[9:0]) + 1;
    m_vsw  = int'(vword[15:10]) + 1;
    m_vfp  = int'(vword[23:16]);
    m_vbp  = int'(vword[31:24]);
    m_ih = pword[12]; m_iv = pword[11]; m_pf = pword[13]; m_ide = pword[14];
  endtask

  function automatic logic [27:0] m_expect();
    bit hs, vs, act;
    hs  = (bh >= m_hact + m_hfp) && (bh < m_hact + m_hfp + m_hsw);
    vs  = (bv >= m_vact + m_vfp) && (bv < m_vact + m_vfp + m_vsw);
    act = (bh < m_hact) && (bv < m_vact);
    return {hs ^ m_ih, vs ^ m_iv, act ^ m_ide, act, (bh == 0 && bv == 0), m_pf, 11'(bh), 11'(bv)};
  endfunction

  task automatic m_adv();
    bh++;
    if (bh == m_hact + m_hfp + m_hsw + m_hbp) begin
      bh = 0;
      bv++;
      if (bv == m_vact + m_vfp + m_vsw + m_vbp) begin
        bv = 0;
        m_load();
      end
    end
  endtask

  task automatic px_step(input int gap, input string tag);
    logic [27:0] held;
    pix_ce = 1'b1;
    @(posedge clk); @(negedge clk);
    pix_ce = 1'b0;
    check(tag, obs, m_expect());
    if (frame_start) begin
      if (fs_first < 0) fs_first = step_n;
      else if (fs_second < 0) fs_second = step_n;
    end
    step_n++;
    m_adv();
    held = obs;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); @(negedge clk);
      check("R8 hold without pix_ce", obs, held);
    end
  endtask

  task automatic start_run(input logic [31:0] h, input logic [31:0] v, input logic [31:0] p);
    enable = 1'b0; pix_ce = 1'b0;
    @(posedge clk); @(negedge clk);
    hword = h; vword = v; pword = p;
    enable = 1'b1;
    m_load();
    bh = 0; bv = 0; step_n = 0; fs_first = -1; fs_second = -1;
    pix_ce = 1'b1;
    @(posedge clk); @(negedge clk);
    pix_ce = 1'b0;
    check("R7 load step quiet", obs, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset outputs", obs, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after release", obs, '0);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      start_run(VEC_H[i], VEC_V[i], VEC_P[i]);
      for (int s = 0; s < 2 * VEC_FRAME[i] + 3; s++)
        px_step(VEC_GAP[i], "R1 R2 R3 R4 R5 raster");
      check("R5 frame period", 28'(fs_second - fs_first), 28'(VEC_FRAME[i]));
    end

    // R6: mid-frame write takes effect next frame
    start_run(VEC_H[0], VEC_V[0], VEC_P[0]);
    for (int s = 0; s < 20; s++) px_step(0, "R6 before write");
    hword = VEC_H[1]; vword = VEC_V[1]; pword = VEC_P[1];
    for (int s = 0; s < 56; s++) px_step(0, "R6 rest of old frame");
    check("R6 old frame ran full length", 28'(pclk_fall), 28'(0));
    for (int s = 0; s < 290; s++) px_step(0, "R6 new frame");
    check("R6 new polarity seen", 28'(pclk_fall), 28'(1));

    // R7: disable mid-frame, no pix_ce needed
    for (int s = 0; s < 7; s++) px_step(0, "R7 running");
    enable = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 stop quiet", obs, '0);
    start_run(VEC_H[2], VEC_V[2], VEC_P[2]);
    px_step(0, "R7 restart first pixel");
    check("R7 R5 restart frame_start", 28'(frame_start), 28'(1));
    for (int s = 0; s < 30; s++) px_step(1, "R7 after restart");

    // R9: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset mid-run", obs, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 quiet after mid-run reset", obs, '0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule